// File: doc/BRIEF.md
# Shared Ready/Data Serial Line Driver

This block drives a single output line that is shared between two jobs inside every conversion period. The period opens with a ready phase. The line first drops LOW for a short marker and then sits HIGH. A data phase follows, in which a 24-bit result word leaves the line MSB-first. The word is paced by a serial clock that an external reader supplies. The reader samples on rising edges, and the block moves the line on falling edges.

The serial clock is asynchronous to the system clock. A synchroniser brings it into the system clock domain before its falling edges are detected. A new result arrives as a one-cycle strobe with its word. The block holds that word and loads it into the output register when the next ready phase begins. The line has a defined level in each read case:
- no read: the MSB stays on the line;
- short read: the last bit placed on the line stays there;
- complete or over-long read: the line goes LOW and stays LOW.

Phase sequencing is a three-state machine with these states:
- `PH_PULSE`: ready marker, line LOW.
- `PH_HOLD`: rest of the ready phase, line HIGH.
- `PH_DATA`: data phase.

It has three transitions:
- `T_PULSE_END`: `PH_PULSE` to `PH_HOLD`, after `PULSE_CYC` cycles.
- `T_READY_END`: `PH_HOLD` to `PH_DATA`, when the ready phase has lasted `READY_CYC` cycles.
- `T_PERIOD_END`: `PH_DATA` to `PH_PULSE`, after `DATA_CYC` data cycles. This transition also clears the bit pointer and loads the held word.

Top module: `rdyshare_tx`

## Requirements
- R1: While `rst_ni` is low, `line_o` is LOW. The block then leaves reset at cycle 0 of a ready phase, with a held word of zero.
- R2: In each period, `line_o` is LOW for the first `PULSE_CYC` system cycles. It is then HIGH until `READY_CYC` cycles have passed since the period began. A period lasts `READY_CYC + DATA_CYC` cycles.
- R3: When the data phase begins, `line_o` carries bit 23 (the MSB) of the output word. It keeps that bit until a serial clock falling edge is seen.
- R4: Each falling edge of `sclk_i` during the data phase is seen after a two-flop synchroniser. Each one moves `line_o` to the next lower bit of the word, so bits leave MSB-first.
- R5: After k falling edges with 1 ≤ k ≤ 23, `line_o` holds word bit 23−k until the data phase ends.
- R6: Once 24 or more falling edges have been seen in a data phase, `line_o` is LOW for the rest of that phase.
- R7: The output word is loaded at the start of each ready phase. It is the last word offered with `res_vld_i` high before that period began.
- R8: A strobe on `res_vld_i` during a data phase does not change the bits shown in that phase.
- R9: Serial clock edges during the ready phase are ignored. The bit pointer restarts at the MSB in every period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the reader, idle LOW, asynchronous |
| res_vld_i | input | 1 | One-cycle strobe: a new result word is present |
| res_word_i | input | 24 | New result word |
| line_o | output | 1 | Shared ready/data line |

## Verification
On every cycle the assertions check these properties:
- the ready marker is LOW;
- the pointer is zero outside the data phase, never runs past the word width, and moves by at most one step;
- the MSB is shown at pointer zero;
- the line is LOW once the pointer reaches the end of the word;
- the output word is stable for the whole data phase;
- the line is steady while the pointer is steady.

Some behaviour is visible only in the bench's scenarios:
- the end-to-end bit order and the held level for each read length (none, short, exactly 24, over-long);
- that a word strobed in one period appears only in the next;
- that a falling edge placed inside the ready phase leaves the next data phase starting at the MSB.

// File: rtl/rdyshare_pkg.sv
package rdyshare_pkg;

    typedef enum logic [1:0] {
        PH_PULSE = 2'd0,
        PH_HOLD  = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

endpackage

// File: rtl/rdyshare_sync.sv
module rdyshare_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic fall_o
);

    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/rdyshare_seq.sv
module rdyshare_seq
    import rdyshare_pkg::*;
#(
    parameter int PULSE_CYC = 3,
    parameter int READY_CYC = 8,
    parameter int DATA_CYC  = 320,
    localparam int PERIOD   = READY_CYC + DATA_CYC,
    localparam int CNT_W    = $clog2(PERIOD)
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    output phase_e phase_o,
    output logic   wrap_o
);

    phase_e             state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PH_PULSE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: T_PULSE_END, T_READY_END, T_PERIOD_END
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        wrap_o  = 1'b0;
        unique case (state_q)
            PH_PULSE: begin
                if (cnt_q == CNT_W'(PULSE_CYC - 1)) state_d = PH_HOLD;
            end
            PH_HOLD: begin
                if (cnt_q == CNT_W'(READY_CYC - 1)) state_d = PH_DATA;
            end
            PH_DATA: begin
                if (cnt_q == CNT_W'(PERIOD - 1)) begin
                    state_d = PH_PULSE;
                    cnt_d   = '0;
                    wrap_o  = 1'b1;
                end
            end
            default: begin
                state_d = PH_PULSE;
                cnt_d   = '0;
            end
        endcase
    end

    assign phase_o = state_q;

endmodule

// File: rtl/rdyshare_ptr.sv
module rdyshare_ptr #(
    parameter int WORD_W  = 24,
    localparam int PTR_W  = $clog2(WORD_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_data_i,
    input  logic             fall_i,
    input  logic             clr_i,
    output logic [PTR_W-1:0] ptr_o
);

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else if (clr_i) begin
            ptr_q <= '0;
        end else if (in_data_i && fall_i && (ptr_q != PTR_W'(WORD_W))) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/rdyshare_tx.sv
module rdyshare_tx
    import rdyshare_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int PULSE_CYC   = 3,
    parameter int READY_CYC   = 8,
    parameter int DATA_CYC    = 320,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = $clog2(WORD_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              res_vld_i,
    input  logic [WORD_W-1:0] res_word_i,
    output logic              line_o
);

    phase_e             phase;
    logic               wrap;
    logic               sclk_fall;
    logic [PTR_W-1:0]   ptr;
    logic [WORD_W-1:0]  pend_q;
    logic [WORD_W-1:0]  word_q;
    logic [WORD_W-1:0]  word_sh;

    rdyshare_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (sclk_i),
        .fall_o  (sclk_fall)
    );

    rdyshare_seq #(
        .PULSE_CYC (PULSE_CYC),
        .READY_CYC (READY_CYC),
        .DATA_CYC  (DATA_CYC)
    ) seq_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_o (phase),
        .wrap_o  (wrap)
    );

    rdyshare_ptr #(.WORD_W(WORD_W)) ptr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .in_data_i (phase == PH_DATA),
        .fall_i    (sclk_fall),
        .clr_i     (wrap),
        .ptr_o     (ptr)
    );

    // result holding and load at the start of a ready phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= '0;
            word_q <= '0;
        end else begin
            if (res_vld_i) pend_q <= res_word_i;
            if (wrap)      word_q <= res_vld_i ? res_word_i : pend_q;
        end
    end

    assign word_sh = word_q << ptr;

    // output process
    always_comb begin
        unique case (phase)
            PH_PULSE: line_o = 1'b0;
            PH_HOLD:  line_o = 1'b1;
            PH_DATA:  line_o = (ptr == PTR_W'(WORD_W)) ? 1'b0 : word_sh[WORD_W-1];
            default:  line_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rdyshare_chk.sv
module rdyshare_chk
    import rdyshare_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int PTR_W  = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input phase_e            phase,
    input logic [PTR_W-1:0]  ptr,
    input logic [WORD_W-1:0] word_q,
    input logic              line_o
);

    p_pulse_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase == PH_PULSE |-> !line_o);

    p_msb_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_DATA && ptr == '0) |-> line_o == word_q[WORD_W-1]);

    p_ptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase == PH_DATA |=> (ptr == $past(ptr)) || (ptr == $past(ptr) + 1'b1) || (ptr == '0));

    p_line_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_DATA && $past(phase) == PH_DATA && $stable(ptr)) |-> $stable(line_o));

    p_ptr_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr <= PTR_W'(WORD_W));

    p_over_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_DATA && ptr == PTR_W'(WORD_W)) |-> !line_o);

    p_word_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_DATA && $past(phase) == PH_DATA) |-> $stable(word_q));

    p_ptr_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase != PH_DATA |-> ptr == '0);

endmodule

bind rdyshare_tx rdyshare_chk #(.WORD_W(WORD_W), .PTR_W(PTR_W)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase  (phase),
    .ptr    (ptr),
    .word_q (word_q),
    .line_o (line_o)
);

// File: tb/rdyshare_tx_tb_top.sv
`timescale 1ns/1ps
module rdyshare_tx_tb_top;

    localparam int WORD_W    = 24;
    localparam int PULSE_CYC = 3;
    localparam int READY_CYC = 8;
    localparam int DATA_CYC  = 320;
    localparam int PERIOD    = READY_CYC + DATA_CYC;
    localparam int N_PER     = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sclk = 1'b0;
    logic              vld = 1'b0;
    logic [WORD_W-1:0] word = '0;
    logic              line;

    int vectors = 0;
    int fails   = 0;
    int pos     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    rdyshare_tx #(
        .WORD_W    (WORD_W),
        .PULSE_CYC (PULSE_CYC),
        .READY_CYC (READY_CYC),
        .DATA_CYC  (DATA_CYC)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sclk_i     (sclk),
        .res_vld_i  (vld),
        .res_word_i (word),
        .line_o     (line)
    );

    // position in the period, counted from reset release
    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else        pos <= (pos == PERIOD - 1) ? 0 : pos + 1;
    end

    function automatic logic exp_bit(logic [WORD_W-1:0] w, int k);
        if (k >= WORD_W) return 1'b0;
        return w[WORD_W-1-k];
    endfunction

    task automatic check(string req, logic exp);
        vectors++;
        if (line !== exp) begin
            fails++;
            $display("FAIL %s: pos=%0d line=%b expected=%b", req, pos, line, exp);
        end
    endtask

    task automatic wait_pos(int p);
        do @(negedge clk); while (pos != p);
    endtask

    task automatic sclk_pulses(int k);
        for (int i = 0; i < k; i++) begin
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: line=%b expected=run end", line);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0] cur_w;
        logic [WORD_W-1:0] nxt_w;
        bit                late_edge;
        int                k;
        void'($urandom(32'd20240611));
        cur_w     = '0;
        nxt_w     = '0;
        late_edge = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset level", 1'b0);
        rst_n = 1'b1;
        for (int p = 0; p < N_PER; p++) begin
            unique case (p)
                0: k = 0;
                1: k = 24;
                2: k = 27;
                3: k = 1;
                4: k = 23;
                5: k = 0;
                default: k = $urandom_range(0, 30);
            endcase
            wait_pos(1);
            check("R2 ready marker low", 1'b0);
            if (late_edge) begin
                sclk = 1'b0;    // falling edge inside the ready phase (R9)
                late_edge = 1'b0;
            end
            wait_pos(PULSE_CYC);
            check("R2 ready hold high", 1'b1);
            wait_pos(READY_CYC - 1);
            check("R2 ready hold high end", 1'b1);
            wait_pos(READY_CYC + 1);
            check("R3 R7 R9 MSB of loaded word", exp_bit(cur_w, 0));
            // strobe the next word inside this data phase (R8)
            nxt_w = (p == 0) ? 24'h800001 : (p == 1) ? 24'h7FFFFF : WORD_W'($urandom);
            word  = nxt_w;
            vld   = 1'b1;
            @(negedge clk);
            vld   = 1'b0;
            word  = '0;
            @(negedge clk);
            check("R8 word steady after strobe", exp_bit(cur_w, 0));
            if (k >= 3) begin
                sclk_pulses(2);
                repeat (2) @(negedge clk);
                check("R4 bit order after two edges", exp_bit(cur_w, 2));
                sclk_pulses(k - 2);
            end else begin
                sclk_pulses(k);
            end
            repeat (4) @(negedge clk);
            if (k >= WORD_W) check("R6 line low after full read", 1'b0);
            else             check("R5 held bit after partial read", exp_bit(cur_w, k));
            wait_pos(PERIOD - 3);
            if (p == 5) begin
                sclk = 1'b1;
                late_edge = 1'b1;
            end
            wait_pos(PERIOD - 1);
            if (k >= WORD_W) check("R6 low to phase end", 1'b0);
            else             check("R5 held to phase end", exp_bit(cur_w, k));
            cur_w = nxt_w;
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule